// File: doc/BRIEF.md
# Condition Code Flag Generator

This block keeps an 8-bit condition code register and updates its four arithmetic flags (negative, zero, overflow, carry) from an operation that a datapath has just finished. The datapath supplies both operands, the result it produced and a code for the kind of operation: add, subtract, shift or test. A width select chooses byte or word interpretation. The block does not compute the result. It derives the flags from the sign bits of the operands and the result, and from whether the result is zero.

The register also holds four system bits: stop-disable, extra interrupt mask, half carry and interrupt mask. This block never alters them, so they keep the values they had at reset. A flag that a given operation does not define keeps its previous value. The register changes only on a rising clock edge when the update strobe is high, and the new value shows on the output from that edge.

Top module: `ccr_flag_unit`

## Requirements
- R1: After reset the register reads 0xD0. The bit layout is S=7, X=6, H=5, I=4, N=3, Z=2, V=1, C=0.
- R2: On a clock edge with `upd_en` low, the register keeps its value.
- R3: `op_sel` encodes 0=add, 1=subtract, 2=shift, 3=test. When `wide` is 0, only bits 7:0 of the operands and result are used, and bits 15:8 have no effect. When `wide` is 1, all 16 bits are used.
- R4: For add, C becomes the sign bit of (a&b)|(b&~r)|(a&~r).
- R5: For add, V becomes the sign bit of (a&b&~r)|(~a&~b&r).
- R6: For subtract, C becomes the sign bit of (~a&b)|(b&r)|(~a&r), and V becomes the sign bit of (a&~b&~r)|(~a&b&r).
- R7: For every operation, N takes the sign bit of the result (bit 7 or bit 15), and Z is 1 exactly when the selected result bits are all zero.
- R8: For shift, C keeps its previous value, and V becomes the new N XOR that previous C.
- R9: For test, V is cleared and C keeps its previous value.
- R10: Bits 7:4 never change after reset.
- R11: A strobed update is visible on `ccr_q` right after the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Update strobe |
| op_sel | input | 2 | Operation class (0 add, 1 sub, 2 shift, 3 test) |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand |
| result | input | 16 | Result produced by the datapath |
| ccr_q | output | 8 | Condition code register |

## Verification
The interesting case is when a flag written by one update feeds the next update in the following cycle. A shift or a test strobed right after an add or subtract must reuse the carry that update just wrote, and the shift overflow must combine that carry with the new sign. The bench issues back-to-back strobes with random operation classes and follows the carry in its own model, so every cycle is compared against the model's value carried over from the previous cycle. Directed sequences put a carry-setting add directly in front of a shift and a test.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    parameter int unsigned CCR_W = 8;
    parameter logic [CCR_W-1:0] CCR_RESET = 8'hD0;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_SHIFT = 2'd2,
        OP_TEST  = 2'd3
    } ccr_op_e;

    // packed MSB first: layout S X H I N Z V C
    typedef struct packed {
        logic s;
        logic x;
        logic h;
        logic i;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c_add;
        logic v_add;
        logic c_sub;
        logic v_sub;
    } flag_cand_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/ccr_width_flags.sv
module ccr_width_flags
    import ccr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] r,
    output flag_cand_t   cand
);
    localparam int unsigned MSB = W - 1;

    logic [W-1:0] carry_add_vec;
    logic [W-1:0] ovf_add_vec;
    logic [W-1:0] borrow_vec;
    logic [W-1:0] ovf_sub_vec;

    always_comb begin
        carry_add_vec = (a & b) | (b & ~r) | (a & ~r);
        ovf_add_vec   = (a & b & ~r) | (~a & ~b & r);
        borrow_vec    = (~a & b) | (b & r) | (~a & r);
        ovf_sub_vec   = (a & ~b & ~r) | (~a & b & r);

        cand.n     = r[MSB];
        cand.z     = (r == '0);
        cand.c_add = carry_add_vec[MSB];
        cand.v_add = ovf_add_vec[MSB];
        cand.c_sub = borrow_vec[MSB];
        cand.v_sub = ovf_sub_vec[MSB];
    end

endmodule

// File: rtl/ccr_op_select.sv
module ccr_op_select
    import ccr_pkg::*;
(
    input  flag_cand_t cand_narrow,
    input  flag_cand_t cand_wide,
    input  logic       wide,
    input  ccr_op_e    op,
    input  logic       c_prev,
    input  logic       v_prev,
    output nzvc_t      flags
);
    flag_cand_t cand;

    always_comb begin
        cand    = wide ? cand_wide : cand_narrow;
        flags.n = cand.n;
        flags.z = cand.z;
        flags.v = v_prev;
        flags.c = c_prev;
        unique case (op)
            OP_ADD: begin
                flags.c = cand.c_add;
                flags.v = cand.v_add;
            end
            OP_SUB: begin
                flags.c = cand.c_sub;
                flags.v = cand.v_sub;
            end
            OP_SHIFT: begin
                flags.v = cand.n ^ c_prev;
            end
            OP_TEST: begin
                flags.v = 1'b0;
            end
            default: begin
                flags.v = v_prev;
            end
        endcase
    end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
    import ccr_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [1:0]        op_sel,
    input  logic              wide,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [DATA_W-1:0] result,
    output logic [CCR_W-1:0]  ccr_q
);
    localparam int unsigned N_WIDTHS = 2;

    typedef struct packed {
        ccr_t ccr;
    } state_t;

    state_t     st_d, st_q;
    flag_cand_t cand [N_WIDTHS];
    nzvc_t      new_flags;
    ccr_op_e    op;

    assign op = ccr_op_e'(op_sel);

    for (genvar gi = 0; gi < N_WIDTHS; gi++) begin : g_width
        localparam int unsigned W = (gi == 0) ? NARROW_W : DATA_W;
        ccr_width_flags #(.W(W)) u_flags (
            .a    (opnd_a[W-1:0]),
            .b    (opnd_b[W-1:0]),
            .r    (result[W-1:0]),
            .cand (cand[gi])
        );
    end

    ccr_op_select u_sel (
        .cand_narrow (cand[0]),
        .cand_wide   (cand[1]),
        .wide        (wide),
        .op          (op),
        .c_prev      (st_q.ccr.c),
        .v_prev      (st_q.ccr.v),
        .flags       (new_flags)
    );

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.ccr.n = new_flags.n;
            st_d.ccr.z = new_flags.z;
            st_d.ccr.v = new_flags.v;
            st_d.ccr.c = new_flags.c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= state_t'(CCR_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign ccr_q = st_q.ccr;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> $stable(ccr_q)); // R2
    AST_SYS_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ccr_q[7:4])); // R10
    AST_SHIFT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel == 2'd2) |=> (ccr_q[1] == (ccr_q[3] ^ ccr_q[0]))); // R8
    AST_SHIFT_CARRY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel == 2'd2) |=> $stable(ccr_q[0])); // R8
    AST_TEST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_sel == 2'd3) |=> (!ccr_q[1] && $stable(ccr_q[0]))); // R9
    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> !(ccr_q[2] && ccr_q[3])); // R7

endmodule

// File: tb/ccr_flag_unit_bench.sv
module ccr_flag_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic        wide = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [15:0] result = '0;
    logic [7:0]  ccr_q;
    logic [7:0]  model = 8'hD0;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    ccr_flag_unit u_ccr_flag_unit (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sel(op_sel),
        .wide(wide), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .ccr_q(ccr_q)
    );

    function automatic logic [7:0] ref_ccr(input logic [7:0] c, input logic [1:0] op,
                                           input logic wd, input logic [15:0] a,
                                           input logic [15:0] b, input logic [15:0] r);
        int msb;
        logic n, z, v, cy;
        logic [15:0] t_ca, t_va, t_cs, t_vs;
        msb  = wd ? 15 : 7;
        t_ca = (a & b) | (b & ~r) | (a & ~r);
        t_va = (a & b & ~r) | (~a & ~b & r);
        t_cs = (~a & b) | (b & r) | (~a & r);
        t_vs = (a & ~b & ~r) | (~a & b & r);
        n  = r[msb];
        z  = wd ? (r == 16'h0) : (r[7:0] == 8'h0);
        v  = c[1];
        cy = c[0];
        case (op)
            2'd0: begin cy = t_ca[msb]; v = t_va[msb]; end
            2'd1: begin cy = t_cs[msb]; v = t_vs[msb]; end
            2'd2: v = n ^ c[0];
            default: v = 1'b0;
        endcase
        return {c[7:4], n, z, v, cy};
    endfunction

    task automatic check(input string tag, input logic [7:0] exp);
        total++;
        if (ccr_q !== exp) begin
            bad++;
            $display("FAIL %s: ccr_q=%02h expected=%02h", tag, ccr_q, exp);
        end
    endtask

    task automatic step(input string tag, input logic en, input logic [1:0] op,
                        input logic wd, input logic [15:0] a, input logic [15:0] b,
                        input logic [15:0] r);
        @(negedge clk);
        upd_en = en; op_sel = op; wide = wd; opnd_a = a; opnd_b = b; result = r;
        if (en) model = ref_ccr(model, op, wd, a, b, r);
        @(posedge clk);
        #1;
        check(tag, model);
    endtask

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog: ccr_q=%02h expected=done", ccr_q);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        #12;
        check("R1 reset", 8'hD0);
        rst_n = 1'b1;
        step("R2 idle", 1'b0, 2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000);
        check("R1 layout after idle", 8'hD0);
        // add 0x7F+0x01 -> 0x80: N=1 V=1 C=0
        step("R5 add ovf", 1'b1, 2'd0, 1'b0, 16'h007F, 16'h0001, 16'h0080);
        check("R5 add ovf abs", 8'hDA);
        // add 0xFF+0x01 -> 0x00: Z=1 C=1
        step("R4 add carry", 1'b1, 2'd0, 1'b0, 16'h00FF, 16'h0001, 16'h0000);
        check("R4 add carry abs", 8'hD5);
        // shift right after carry: r=0x80 -> N=1 V=1^1=0 C kept
        step("R8 shift after carry", 1'b1, 2'd2, 1'b0, 16'h0, 16'h0, 16'h0080);
        check("R8 shift abs", 8'hD9);
        // test keeps C, clears V
        step("R9 test", 1'b1, 2'd3, 1'b0, 16'h0, 16'h0, 16'h0000);
        check("R9 test abs", 8'hD5);
        // sub 0x00-0x01 -> 0xFF: N=1 C=1
        step("R6 sub borrow", 1'b1, 2'd1, 1'b0, 16'h0000, 16'h0001, 16'h00FF);
        check("R6 sub borrow abs", 8'hD9);
        // 16-bit 0x8000-0x0001 -> 0x7FFF: V=1 C=0
        step("R6 sub ovf wide", 1'b1, 2'd1, 1'b1, 16'h8000, 16'h0001, 16'h7FFF);
        check("R6 sub ovf abs", 8'hD2);
        // narrow ignores upper bits: result low byte zero
        step("R3 narrow ignores high", 1'b1, 2'd3, 1'b0, 16'hAB00, 16'hCD00, 16'hFF00);
        check("R3 narrow abs", 8'hD4);
        step("R7 wide zero", 1'b1, 2'd3, 1'b1, 16'h0, 16'h0, 16'h0000);
        step("R11 shift wide neg", 1'b1, 2'd2, 1'b1, 16'h0, 16'h0, 16'h8001);
        step("R2 hold after update", 1'b0, 2'd1, 1'b1, 16'hFFFF, 16'h1, 16'h0);
        for (int k = 0; k < 400; k++) begin
            logic [15:0] ra, rb, rr;
            logic [1:0]  rop;
            logic        rw, ren;
            ra  = 16'($urandom);
            rb  = 16'($urandom);
            rop = 2'($urandom);
            rw  = 1'($urandom);
            ren = ($urandom % 8) != 0;
            case ($urandom % 4)
                0: rr = 16'h0;
                1: rr = {8'($urandom), 8'h00};
                2: rr = (rop == 2'd1) ? ra - rb : ra + rb;
                default: rr = 16'($urandom);
            endcase
            step("R4 R5 R6 R7 R8 R9 R10 random", ren, rop, rw, ra, rb, rr);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule